// File: doc/BRIEF.md
# ADC Result Threshold Watcher

This block sits beside a multi-channel analog-to-digital converter and watches its results without software involvement. Each of its monitors is tied to one converter channel. Every time that channel reports a finished conversion, the monitor tests the 12-bit result against its own threshold. The test is either "below the threshold" or "at or above the threshold".

A monitor keeps a count of back-to-back passing results for its channel. A failing result sets the count back to zero. When the count reaches the programmed run length, the monitor raises a sticky flag. This means a single noisy sample that crosses the threshold is not reported. Software uses the flag, or the shared interrupt request, to learn that an input voltage has settled on one side of its limit. Two monitors are built by default, and each has its own channel, threshold, condition, run length and counter.

The configuration arrives as plain register-level inputs from a surrounding register file. The flag is cleared through a one-cycle clear pulse, which represents a software write of 1 to the flag bit.

Top module: `adc_cmp_monitor`

## Requirements
- R1: After reset every flag is 0, every run counter is 0, and `irq` is 0.
- R2: A monitor evaluates a result only in a cycle where `res_valid` is 1, the monitor is enabled, and `res_chan` equals that monitor's 6-bit channel select. Results for other channels, or cycles with `res_valid` low, leave its run count unchanged.
- R3: If the condition bit is 0, a result passes when it is strictly less than the threshold. If the condition bit is 1, a result passes when it is greater than or equal to the threshold. A result equal to the threshold therefore fails with condition 0 and passes with condition 1.
- R4: Each evaluated result that passes adds one to the run count. Each evaluated result that fails sets the run count to zero.
- R5: The required run is the 4-bit match-count field plus one, giving 1 to 16. The flag becomes 1 on the clock edge that samples the passing result which brings the run to the required length.
- R6: The flag is sticky: failing results, disabling the monitor and later results do not clear it. Only a `flag_clr` pulse on the monitor's bit clears it. If a set event and a clear pulse occur in the same cycle, the set wins.
- R7: Once the run reaches the required length, it holds there and does not wrap. If the flag is cleared while the run is held, the next passing result sets the flag again.
- R8: While a monitor is disabled, its run count is held at zero.
- R9: `irq` is 1 exactly when some monitor has its flag set and its interrupt-enable bit is 1. `irq` follows changes to the enable bits in the same cycle.
- R10: The monitors are independent. A result, flag or clear on one monitor does not change the state of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Conversion-complete strobe, one cycle per result |
| res_chan | input | 6 | Channel number of the completed conversion |
| res_data | input | 12 | Conversion result |
| cfg_en | input | 2 | Per-monitor enable |
| cfg_ge | input | 2 | Per-monitor condition: 0 = below, 1 = at or above |
| cfg_ie | input | 2 | Per-monitor interrupt enable |
| cfg_chan | input | 12 | Per-monitor channel select, 6 bits each, monitor 0 in the low bits |
| cfg_thresh | input | 24 | Per-monitor threshold, 12 bits each, monitor 0 in the low bits |
| cfg_mcnt | input | 8 | Per-monitor match count, 4 bits each; the required run is the field plus one |
| flag_clr | input | 2 | Per-monitor one-cycle flag clear pulse |
| cmp_flag | output | 2 | Per-monitor sticky flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `flag_clr` is a short pulse and that the configuration of a monitor stays stable while results for its channel are being evaluated. The one exception is the enable bit, which may drop at any time. The stimulus changes the configuration only between result strobes and only while `res_valid` is low. It raises each strobe for a single cycle, and it drives every input on the falling clock edge so that each rising edge sees settled values.

// File: rtl/adcmon_pkg.sv
package adcmon_pkg;

  // Comparison condition selected per monitor
  typedef enum logic {
    CMP_BELOW = 1'b0,
    CMP_AT_OR_ABOVE = 1'b1
  } adcmon_cond_e;

endpackage

// File: rtl/adcmon_cmp.sv
module adcmon_cmp
  import adcmon_pkg::*;
#(
  parameter int CH_W   = 6,
  parameter int DATA_W = 12
) (
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic              en,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [DATA_W-1:0] thresh,
  input  logic              ge,
  output logic              hit,
  output logic              pass
);

  // Threshold test for one result
  function automatic logic test_result(input logic [DATA_W-1:0] value,
                                       input logic [DATA_W-1:0] limit,
                                       input adcmon_cond_e cond);
    if (cond == CMP_AT_OR_ABOVE) return value >= limit;
    return value < limit;
  endfunction

  adcmon_cond_e cond;

  always_comb begin
    cond = adcmon_cond_e'(ge);
    hit  = res_valid && en && (res_chan == sel_chan);
    pass = test_result(res_data, thresh, cond);
  end

endmodule

// File: rtl/adcmon_run_ctr.sv
module adcmon_run_ctr #(
  parameter int MCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hit,
  input  logic              pass,
  input  logic [MCNT_W-1:0] mcnt,
  input  logic              clr,
  output logic              flag
);

  localparam int RUN_W = MCNT_W + 1;

  // Next run length: saturates at the required length, clears on a fail
  function automatic logic [RUN_W-1:0] next_run(input logic [RUN_W-1:0] cur,
                                                input logic [RUN_W-1:0] req,
                                                input logic ok);
    if (!ok) return '0;
    if (cur >= req) return req;
    return cur + 1'b1;
  endfunction

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;
  logic [RUN_W-1:0] need;
  logic             set_evt;
  logic             flag_q;

  always_comb begin
    need    = {1'b0, mcnt} + 1'b1;
    run_nxt = next_run(run_q, need, pass);
    set_evt = hit && pass && (run_nxt == need);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!en) begin
      run_q <= '0;
    end else if (hit) begin
      run_q <= run_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_evt) begin
      flag_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;

  // R4
  fail_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pass) |=> (run_q == '0));

  // R4
  pass_grows_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pass && (run_q < need)) |=> (run_q == $past(run_q) + 1'b1));

  // R8
  disabled_run_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (run_q == '0));

  // R2
  no_hit_holds_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit) |=> $stable(run_q));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R5
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit && pass));

  // R7
  run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pass) |=> (run_q <= $past(need)));

endmodule

// File: rtl/adc_cmp_monitor.sv
module adc_cmp_monitor #(
  parameter int NUM_MON = 2,
  parameter int CH_W    = 6,
  parameter int DATA_W  = 12,
  parameter int MCNT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      res_valid,
  input  logic [CH_W-1:0]           res_chan,
  input  logic [DATA_W-1:0]         res_data,
  input  logic [NUM_MON-1:0]        cfg_en,
  input  logic [NUM_MON-1:0]        cfg_ge,
  input  logic [NUM_MON-1:0]        cfg_ie,
  input  logic [NUM_MON*CH_W-1:0]   cfg_chan,
  input  logic [NUM_MON*DATA_W-1:0] cfg_thresh,
  input  logic [NUM_MON*MCNT_W-1:0] cfg_mcnt,
  input  logic [NUM_MON-1:0]        flag_clr,
  output logic [NUM_MON-1:0]        cmp_flag,
  output logic                      irq
);

  logic [NUM_MON-1:0] mon_hit;
  logic [NUM_MON-1:0] mon_pass;

  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    adcmon_cmp #(
      .CH_W  (CH_W),
      .DATA_W(DATA_W)
    ) u_cmp (
      .res_valid(res_valid),
      .res_chan (res_chan),
      .res_data (res_data),
      .en       (cfg_en[m]),
      .sel_chan (cfg_chan[m*CH_W +: CH_W]),
      .thresh   (cfg_thresh[m*DATA_W +: DATA_W]),
      .ge       (cfg_ge[m]),
      .hit      (mon_hit[m]),
      .pass     (mon_pass[m])
    );

    adcmon_run_ctr #(
      .MCNT_W(MCNT_W)
    ) u_run (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (cfg_en[m]),
      .hit  (mon_hit[m]),
      .pass (mon_pass[m]),
      .mcnt (cfg_mcnt[m*MCNT_W +: MCNT_W]),
      .clr  (flag_clr[m]),
      .flag (cmp_flag[m])
    );
  end

  assign irq = |(cmp_flag & cfg_ie);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cmp_flag != '0));

  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_hit != '0) |-> res_valid);

endmodule

// File: tb/adc_cmp_monitor_tb.sv
module adc_cmp_monitor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [5:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic [1:0]  cfg_en = '0;
  logic [1:0]  cfg_ge = '0;
  logic [1:0]  cfg_ie = '0;
  logic [11:0] cfg_chan = '0;
  logic [23:0] cfg_thresh = '0;
  logic [7:0]  cfg_mcnt = '0;
  logic [1:0]  flag_clr = '0;
  logic [1:0]  cmp_flag;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  adc_cmp_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .cfg_en(cfg_en), .cfg_ge(cfg_ge), .cfg_ie(cfg_ie),
    .cfg_chan(cfg_chan), .cfg_thresh(cfg_thresh), .cfg_mcnt(cfg_mcnt),
    .flag_clr(flag_clr), .cmp_flag(cmp_flag), .irq(irq)
  );

  task automatic check(input int got, input int exp, input string what);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  // Inputs change on falling edges; outputs are read on the next falling edge
  task automatic send(input logic [5:0] ch, input logic [11:0] d, input logic v = 1'b1);
    res_valid = v; res_chan = ch; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic set_mon(input int m, input logic en, input logic [5:0] ch,
                         input logic ge, input logic [11:0] thr,
                         input logic [3:0] mc, input logic ie);
    cfg_en[m] = en; cfg_ge[m] = ge; cfg_ie[m] = ie;
    cfg_chan[m*6 +: 6] = ch; cfg_thresh[m*12 +: 12] = thr; cfg_mcnt[m*4 +: 4] = mc;
  endtask

  task automatic clear_all();
    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
    cfg_en = 2'b00;
    @(negedge clk);
    cfg_en = 2'b00;
  endtask

  task automatic t_reset();
    check(cmp_flag, 0, "R1 flags after reset");
    check(irq, 0, "R1 irq after reset");
  endtask

  task automatic t_below_run();
    set_mon(0, 1, 6'd5, 0, 12'h800, 4'd2, 1);
    @(negedge clk);
    send(6'd5, 12'h100);
    send(6'd5, 12'h7FF);
    check(cmp_flag[0], 0, "R5 no flag after two of three");
    send(6'd5, 12'h000);
    check(cmp_flag[0], 1, "R5 flag on third pass");
    check(irq, 1, "R9 irq with enable");
    send(6'd5, 12'hFFF);
    check(cmp_flag[0], 1, "R6 flag sticky after fail");
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    check(cmp_flag[0], 0, "R6 clear pulse");
    check(irq, 0, "R9 irq drops with flag");
    clear_all();
  endtask

  task automatic t_fail_resets();
    set_mon(0, 1, 6'd5, 0, 12'h800, 4'd2, 0);
    @(negedge clk);
    send(6'd5, 12'h010);
    send(6'd5, 12'h020);
    send(6'd5, 12'h800);      // equal fails in below mode
    send(6'd5, 12'h030);
    send(6'd5, 12'h040);
    check(cmp_flag[0], 0, "R4 run restarted after equal result (R3)");
    send(6'd5, 12'h050);
    check(cmp_flag[0], 1, "R4 flag after fresh run");
    clear_all();
  endtask

  task automatic t_ge_edge();
    set_mon(0, 1, 6'd7, 1, 12'h3FF, 4'd0, 0);
    @(negedge clk);
    send(6'd7, 12'h3FE);
    check(cmp_flag[0], 0, "R3 one below threshold fails in at-or-above");
    send(6'd7, 12'h3FF);
    check(cmp_flag[0], 1, "R3 equal passes in at-or-above");
    clear_all();
  endtask

  task automatic t_other_chan();
    set_mon(0, 1, 6'd5, 0, 12'h800, 4'd1, 0);
    @(negedge clk);
    send(6'd5, 12'h100);
    send(6'd6, 12'hFFF);              // other channel, failing value
    send(6'd5, 12'hFFF, 1'b0);        // strobe low, failing value
    check(cmp_flag[0], 0, "R2 no flag yet");
    send(6'd5, 12'h100);
    check(cmp_flag[0], 1, "R2 run kept across ignored results");
    clear_all();
  endtask

  task automatic t_disable();
    set_mon(0, 1, 6'd5, 0, 12'h800, 4'd1, 0);
    @(negedge clk);
    send(6'd5, 12'h100);
    cfg_en[0] = 1'b0;
    @(negedge clk);
    cfg_en[0] = 1'b1;
    send(6'd5, 12'h100);
    check(cmp_flag[0], 0, "R8 disable cleared run");
    send(6'd5, 12'h100);
    check(cmp_flag[0], 1, "R8 flag after new run");
    clear_all();
  endtask

  task automatic t_saturate();
    set_mon(0, 1, 6'd5, 0, 12'h800, 4'd1, 0);
    @(negedge clk);
    send(6'd5, 12'h100);
    send(6'd5, 12'h100);
    send(6'd5, 12'h100);
    check(cmp_flag[0], 1, "R7 flag set");
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    check(cmp_flag[0], 0, "R7 cleared");
    send(6'd5, 12'h100);
    check(cmp_flag[0], 1, "R7 one pass re-flags while held");
    flag_clr = 2'b01;
    send(6'd5, 12'h100);
    flag_clr = 2'b00;
    check(cmp_flag[0], 1, "R6 set wins over clear");
    clear_all();
  endtask

  task automatic t_max_run();
    set_mon(0, 1, 6'd63, 0, 12'hFFF, 4'd15, 0);
    @(negedge clk);
    for (int i = 0; i < 15; i++) send(6'd63, 12'h001);
    check(cmp_flag[0], 0, "R5 no flag after 15 of 16");
    send(6'd63, 12'h001);
    check(cmp_flag[0], 1, "R5 flag after 16");
    clear_all();
  endtask

  task automatic t_indep();
    set_mon(0, 1, 6'd5, 0, 12'h800, 4'd1, 1);
    set_mon(1, 1, 6'd9, 1, 12'hA00, 4'd0, 0);
    @(negedge clk);
    send(6'd5, 12'h100);
    send(6'd9, 12'hB00);
    check(cmp_flag, 2'b10, "R10 only monitor 1 flags");
    check(irq, 0, "R9 irq masked");
    cfg_ie[1] = 1'b1;
    #1;
    check(irq, 1, "R9 irq follows enable");
    send(6'd5, 12'h100);
    check(cmp_flag, 2'b11, "R10 monitor 0 run kept");
    flag_clr = 2'b10;
    @(negedge clk);
    flag_clr = 2'b00;
    check(cmp_flag, 2'b01, "R10 clear hits one monitor");
    check(irq, 1, "R9 irq from monitor 0");
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_below_run();
    t_fail_resets();
    t_ge_edge();
    t_other_chan();
    t_disable();
    t_saturate();
    t_max_run();
    t_indep();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule